// File: doc/BRIEF.md
# Host Window Bridge to DSP Data and Instruction Stores

This block gives a 16-bit host register port indirect access to two on-chip memories: a 16-bit data store and a 32-bit instruction store. The host loads a 32-bit flat access address as two 16-bit halves. It then moves words through data ports, and the address can step forward on its own after each access. One bit of the flat address picks the store. Instruction words cross the 16-bit port as two halves: the low half first, through its own port, and then the high half through the shared data port.

The bridge also offers a read port that clears each word as it returns it. It also holds a pending-interrupt register. DSP-side pulses set its bits, and the host clears bits by writing back the complement of what it read. A single host interrupt line combines every pending bit with an enable bit.

Both stores are synchronous single-port RAMs inside the block. Host reads return data on `hst_rdata`, with `hst_rvalid` high, in the cycle after the read strobe.

Top module: `hostwin_bridge`

## Requirements
- R1: After reset the flat address is zero, the control register is zero, no interrupt is pending, and `host_irq` and `hst_rvalid` are low.
- R2: Writes to register 0 and register 1 load address bits [15:0] and [31:16]. Reads of those registers return the halves. Every read strobe gives `hst_rvalid` high with data in the next cycle and only then.
- R3: When address bit 22 is clear, register 2 reads and writes the data-store word whose index is the low log2(DS_DEPTH) address bits, with no translation. Higher bits alias.
- R4: When address bit 22 is set, the instruction-store index is address bits [log2(IS_DEPTH)+1:2]. A write to register 3 only loads a holding register. A write to register 2 commits {write data, holding register} as one 32-bit word. Register 3 reads the low half and register 2 reads the high half.
- R5: Control bit 1 enables auto-increment. With it set, each register 2 or register 4 access advances the address by 1 for the data store and by 4 for the instruction store. Register 3 accesses never advance it. With bit 1 clear, nothing advances, and control bit 2 has no effect on addressing.
- R6: A read of register 4 returns the same value a register 2 read would return. It also zeroes the addressed word, the full 32 bits for the instruction store.
- R7: Each bit set on `dsp_irq_set` sets that pending bit. A read of register 6 returns the pending bits. A write of value v to register 6 clears each pending bit where v is 0. A set wins over a clear in the same cycle.
- R8: `host_irq` is high one cycle after control bit 0 is set and at least one bit is pending, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_reg | input | 3 | Register number |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| dsp_irq_set | input | IRQ_W | DSP-side interrupt set pulses |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench builds the bridge with a 16-word data store, an 8-word instruction store and four interrupt bits. These sizes let it fill and read back every word of both stores with auto-increment, and check the end address of each sweep. They also make address aliasing past the data-store depth reachable. With four pending bits, every combination of pending value and clear value (256 pairs) is swept, and the host interrupt line is checked for each pair.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  localparam int HOST_W = 16;
  localparam int ADDR_W = 2 * HOST_W;

  typedef enum logic [2:0] {
    RG_ADDR_LO = 3'd0,
    RG_ADDR_HI = 3'd1,
    RG_DATA    = 3'd2,
    RG_ISLO    = 3'd3,
    RG_RDCLR   = 3'd4,
    RG_CTRL    = 3'd5,
    RG_INTR    = 3'd6,
    RG_SPARE   = 3'd7
  } reg_sel_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_REG,
    SRC_DS,
    SRC_IS_LO,
    SRC_IS_HI
  } rd_src_e;

  typedef struct packed {
    logic io_inc;
    logic mem_inc;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/hwb_addr_ctr.sv
module hwb_addr_ctr #(
  parameter int IS_SEL_BIT = 22
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_lo,
  input  logic                       wr_hi,
  input  logic [hwb_pkg::HOST_W-1:0] wdata,
  input  logic                       step,
  output logic [hwb_pkg::ADDR_W-1:0] addr_q,
  output logic                       is_sel
);
  import hwb_pkg::*;
  localparam logic [ADDR_W-1:0] IS_STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DS_STEP = ADDR_W'(1);

  assign is_sel = addr_q[IS_SEL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_lo) begin
      addr_q[HOST_W-1:0] <= wdata;
    end else if (wr_hi) begin
      addr_q[ADDR_W-1:HOST_W] <= wdata;
    end else if (step) begin
      addr_q <= addr_q + (is_sel ? IS_STEP : DS_STEP);
    end
  end

  assert_is_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_lo && !wr_hi && addr_q[IS_SEL_BIT]) |=> (addr_q == $past(addr_q) + 32'd4));
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_lo && !wr_hi) |=> $stable(addr_q));
endmodule

// File: rtl/hwb_store_ram.sv
module hwb_store_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rq
);
  logic [W-1:0] mem [DEPTH];

  // read-first single port: a read-and-clear sees the old word
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) rq <= mem[idx];
  end
endmodule

// File: rtl/hwb_irq_block.sv
module hwb_irq_block #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             clr_wr,
  input  logic [IRQ_W-1:0] keep_mask,
  input  logic             en,
  output logic [IRQ_W-1:0] pend_q,
  output logic             irq_o
);
  logic [IRQ_W-1:0] pend_n;

  always_comb begin
    pend_n = pend_q;
    if (clr_wr) pend_n = pend_q & keep_mask;
    pend_n = pend_n | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq_o  <= en & (|pend_q);
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  assert_no_pend_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |=> !irq_o);
  assert_disabled_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_o);
endmodule

// File: rtl/hostwin_bridge.sv
module hostwin_bridge #(
  parameter int DS_DEPTH   = 1024,
  parameter int IS_DEPTH   = 512,
  parameter int IRQ_W      = 16,
  parameter int IS_SEL_BIT = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_sel,
  input  logic             hst_we,
  input  logic [2:0]       hst_reg,
  input  logic [15:0]      hst_wdata,
  output logic [15:0]      hst_rdata,
  output logic             hst_rvalid,
  input  logic [IRQ_W-1:0] dsp_irq_set,
  output logic             host_irq
);
  import hwb_pkg::*;
  localparam int DS_AW = $clog2(DS_DEPTH);
  localparam int IS_AW = $clog2(IS_DEPTH);
  localparam int IS_W  = 2 * HOST_W;

  reg_sel_e r;
  logic wr, rd, data_wr, data_rd, clr_rd, lo_wr, lo_rd, ctrl_wr, intr_wr;
  logic mem_acc, step, is_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [HOST_W-1:0] hold_q, reg_q;
  ctrl_t ctrl_q;
  rd_src_e src_q;
  logic [IRQ_W-1:0] pend_q;

  assign r       = reg_sel_e'(hst_reg);
  assign wr      = hst_sel & hst_we;
  assign rd      = hst_sel & ~hst_we;
  assign data_wr = wr && (r == RG_DATA);
  assign data_rd = rd && (r == RG_DATA);
  assign clr_rd  = rd && (r == RG_RDCLR);
  assign lo_wr   = wr && (r == RG_ISLO);
  assign lo_rd   = rd && (r == RG_ISLO);
  assign ctrl_wr = wr && (r == RG_CTRL);
  assign intr_wr = wr && (r == RG_INTR);
  assign mem_acc = data_wr | data_rd | clr_rd;
  assign step    = mem_acc & ctrl_q.mem_inc;

  hwb_addr_ctr #(.IS_SEL_BIT(IS_SEL_BIT)) u_addr (
    .clk(clk), .rst(rst),
    .wr_lo(wr && (r == RG_ADDR_LO)),
    .wr_hi(wr && (r == RG_ADDR_HI)),
    .wdata(hst_wdata), .step(step),
    .addr_q(addr_q), .is_sel(is_sel)
  );

  // data store
  logic            ds_we, ds_re;
  logic [HOST_W-1:0] ds_wd, ds_rq;
  assign ds_we = (data_wr | clr_rd) & ~is_sel;
  assign ds_re = (data_rd | clr_rd) & ~is_sel;
  assign ds_wd = clr_rd ? '0 : hst_wdata;

  hwb_store_ram #(.W(HOST_W), .DEPTH(DS_DEPTH)) u_ds (
    .clk(clk), .we(ds_we), .re(ds_re), .idx(addr_q[DS_AW-1:0]),
    .wd(ds_wd), .rq(ds_rq)
  );

  // instruction store
  logic          is_we, is_re;
  logic [IS_W-1:0] is_wd, is_rq;
  assign is_we = (data_wr | clr_rd) & is_sel;
  assign is_re = (data_rd | clr_rd | lo_rd) & is_sel;
  assign is_wd = clr_rd ? '0 : {hst_wdata, hold_q};

  hwb_store_ram #(.W(IS_W), .DEPTH(IS_DEPTH)) u_is (
    .clk(clk), .we(is_we), .re(is_re), .idx(addr_q[IS_AW+1:2]),
    .wd(is_wd), .rq(is_rq)
  );

  hwb_irq_block #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .set_i(dsp_irq_set),
    .clr_wr(intr_wr), .keep_mask(hst_wdata[IRQ_W-1:0]),
    .en(ctrl_q.irq_en), .pend_q(pend_q), .irq_o(host_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (lo_wr)   hold_q <= hst_wdata;
      if (ctrl_wr) ctrl_q <= ctrl_t'(hst_wdata[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rvalid <= 1'b0;
      src_q      <= SRC_NONE;
      reg_q      <= '0;
    end else begin
      hst_rvalid <= rd;
      if (rd) begin
        case (r)
          RG_ADDR_LO: begin src_q <= SRC_REG; reg_q <= addr_q[HOST_W-1:0]; end
          RG_ADDR_HI: begin src_q <= SRC_REG; reg_q <= addr_q[ADDR_W-1:HOST_W]; end
          RG_DATA, RG_RDCLR: src_q <= is_sel ? SRC_IS_HI : SRC_DS;
          RG_ISLO:    src_q <= is_sel ? SRC_IS_LO : SRC_NONE;
          RG_CTRL:    begin src_q <= SRC_REG; reg_q <= {{(HOST_W-3){1'b0}}, ctrl_q}; end
          RG_INTR:    begin src_q <= SRC_REG; reg_q <= HOST_W'(pend_q); end
          default:    src_q <= SRC_NONE;
        endcase
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_REG:   hst_rdata = reg_q;
      SRC_DS:    hst_rdata = ds_rq;
      SRC_IS_LO: hst_rdata = is_rq[HOST_W-1:0];
      SRC_IS_HI: hst_rdata = is_rq[IS_W-1:HOST_W];
      default:   hst_rdata = '0;
    endcase
  end

  assert_rvalid_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd |=> hst_rvalid);
  assert_rvalid_only_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !hst_rvalid);
  assert_lo_no_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (hst_sel && r == RG_ISLO) |=> $stable(addr_q));
  assert_lo_wr_no_store_R4: assert property (@(posedge clk) disable iff (rst)
    lo_wr |-> !is_we && !ds_we);
endmodule

// File: tb/hostwin_bridge_tb.sv
module hostwin_bridge_tb;
  localparam int DSD = 16;
  localparam int ISD = 8;
  localparam int IW  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, we = 1'b0;
  logic [2:0] rg = '0;
  logic [15:0] wd = '0, rdata;
  logic rvalid, irq;
  logic [IW-1:0] iset = '0;
  int checks = 0, errors = 0;
  logic [15:0] ds_m [DSD];
  logic [31:0] is_m [ISD];
  logic [15:0] v;

  always #5 clk = ~clk;

  hostwin_bridge #(.DS_DEPTH(DSD), .IS_DEPTH(ISD), .IRQ_W(IW)) u_dut (
    .clk(clk), .rst(rst), .hst_sel(sel), .hst_we(we), .hst_reg(rg),
    .hst_wdata(wd), .hst_rdata(rdata), .hst_rvalid(rvalid),
    .dsp_irq_set(iset), .host_irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; rg = a; wd = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; rg = a;
    @(negedge clk); sel = 0;
    d = rdata;
    if (rvalid !== 1'b1) begin
      errors++; checks++;
      $display("FAIL R2: actual rvalid %b expected 1", rvalid);
    end
  endtask

  function automatic logic [15:0] dsval(input int i);
    return 16'h5A00 ^ 16'(i * 16'h0123);
  endfunction
  function automatic logic [31:0] isval(input int i);
    return {16'hC000 + 16'(i * 16'h0111), 16'h0F00 ^ 16'(i * 16'h2203)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 rvalid", rvalid, 0);
    hrd(0, v); chk("R1 addr lo", v, 0);
    hrd(1, v); chk("R1 addr hi", v, 0);
    hrd(5, v); chk("R1 ctrl", v, 0);
    hrd(6, v); chk("R1 pend", v, 0);
    // R2 address halves
    hwr(0, 16'h1234); hwr(1, 16'h0041);
    hrd(0, v); chk("R2 lo", v, 16'h1234);
    hrd(1, v); chk("R2 hi", v, 16'h0041);
    @(negedge clk); chk("R2 rvalid idle", rvalid, 0);
    // R3/R5 data store sweep with auto-increment
    hwr(5, 16'h0002); hwr(0, 0); hwr(1, 0);
    for (int i = 0; i < DSD; i++) begin hwr(2, dsval(i)); ds_m[i] = dsval(i); end
    hrd(0, v); chk("R5 ds end addr", v, DSD);
    hwr(0, 0);
    for (int i = 0; i < DSD; i++) begin hrd(2, v); chk("R3 ds read", v, ds_m[i]); end
    hwr(0, 16'(DSD + 3)); hrd(2, v); chk("R3 alias", v, ds_m[3]);
    // R4 instruction store sweep, flat addr = (i<<2)|bit22
    hwr(0, 0); hwr(1, 16'h0040);
    for (int i = 0; i < ISD; i++) begin
      hwr(3, isval(i)[15:0]); hwr(2, isval(i)[31:16]); is_m[i] = isval(i);
    end
    hrd(0, v); chk("R5 is end addr", v, 4 * ISD);
    hrd(1, v); chk("R5 is hi kept", v, 16'h0040);
    hwr(0, 0);
    for (int i = 0; i < ISD; i++) begin
      hrd(3, v); chk("R4 is lo", v, is_m[i][15:0]);
      hrd(2, v); chk("R4 is hi", v, is_m[i][31:16]);
    end
    // R4 low-half write alone does not reach the store; R5 no advance
    hwr(0, 16'd8); hwr(3, 16'hDEAD);
    hrd(0, v); chk("R5 lo no step", v, 8);
    hrd(3, v); chk("R4 hold only", v, is_m[2][15:0]);
    hrd(2, v); chk("R4 hold only hi", v, is_m[2][31:16]);
    // R5 auto-increment off, and io bit without effect
    hwr(5, 0); hwr(1, 0); hwr(0, 5);
    hrd(2, v); hrd(2, v); chk("R5 off reread", v, ds_m[5]);
    hwr(2, 16'hBEEF); ds_m[5] = 16'hBEEF;
    hrd(2, v); chk("R5 off write", v, 16'hBEEF);
    hrd(0, v); chk("R5 off addr", v, 5);
    hwr(5, 16'h0004);
    hrd(2, v); hrd(4, v); ds_m[5] = 0;
    hrd(0, v); chk("R5 io bit", v, 5);
    hrd(2, v); chk("R6 clear no inc", v, 0);
    // R6 read-and-clear sweep on data store
    hwr(5, 16'h0002); hwr(0, 0);
    for (int i = 0; i < 8; i++) begin hrd(4, v); chk("R6 ds rc", v, ds_m[i]); end
    hrd(0, v); chk("R6 rc step", v, 8);
    hwr(0, 0);
    for (int i = 0; i < 8; i++) begin hrd(2, v); chk("R6 ds zero", v, 0); end
    hrd(2, v); chk("R6 ds kept", v, ds_m[8]);
    // R6 on instruction store
    hwr(1, 16'h0040); hwr(0, 4);
    hrd(4, v); chk("R6 is rc", v, is_m[1][31:16]);
    hrd(0, v); chk("R6 is step", v, 8);
    hwr(0, 4);
    hrd(3, v); chk("R6 is lo zero", v, 0);
    hrd(2, v); chk("R6 is hi zero", v, 0);
    hrd(3, v); chk("R6 is neighbour", v, is_m[2][15:0]);
    // R7/R8 exhaustive pending x clear sweep
    hwr(5, 16'h0001);
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        hwr(6, 0);
        @(negedge clk); iset = IW'(s);
        @(negedge clk); iset = '0;
        hrd(6, v); chk("R7 set", v, s);
        chk("R8 irq set", irq, (s != 0));
        hwr(6, 16'(c));
        hrd(6, v); chk("R7 clear", v, s & c);
        chk("R8 irq clear", irq, ((s & c) != 0));
      end
    end
    // R7 set wins over same-cycle clear
    hwr(6, 0);
    @(negedge clk); sel = 1; we = 1; rg = 6; wd = 0; iset = 4'b0100;
    @(negedge clk); sel = 0; we = 0; iset = '0;
    hrd(6, v); chk("R7 set priority", v, 4'b0100);
    // R8 enable gating
    hwr(5, 0); @(negedge clk);
    chk("R8 disabled", irq, 0);
    hwr(5, 16'h0001); @(negedge clk);
    chk("R8 enabled", irq, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule